// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces the 16-bit data memory address for each operand access of a fixed-point signal processor. It has two ways of forming that address. Paged mode joins a 9-bit page register (upper bits) with a 7-bit offset taken from the instruction word. Pointer mode reads one of eight 16-bit pointer registers, chosen by a 3-bit selector. After a pointer-mode access, the chosen register is updated by one of several rules. These include a reversed-carry step that walks FFT buffers in bit-reversed order.

Requests enter on a valid/ready channel. A request carries the mode, the offset, the update code and an optional new selector value. Results leave on a valid/ready channel with a single output register. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high when the output register is empty or its content is being taken in the same cycle. While `addr_valid` is high and `addr_ready` is low, the result is held and no new request is accepted. The page register and the pointer registers also have plain load ports, which act on every cycle regardless of the handshake.

Top module: `dsp_addr_gen`

## Requirements
- R1: For a paged-mode request (`req_indirect`=0), the address is the page register in bits 15:7 and `req_offset` in bits 6:0.
- R2: A `page_wr` pulse loads `page_val` at the clock edge. Requests accepted after that edge use the new page. Page 511 with offset 127 gives 0xFFFF, so the reachable space is 512 pages of 128 words.
- R3: For a pointer-mode request (`req_indirect`=1), the address is the value of the selected pointer register before any update.
- R4: Update codes, applied to the selected register after a pointer-mode access, all wrap modulo 2^16: 0 leaves it unchanged, 1 adds 1, 2 subtracts 1, 3 adds register 0, 4 subtracts register 0, and 7 (reserved) leaves it unchanged.
- R5: Code 5 adds register 0 and code 6 subtracts register 0, with carries and borrows moving from bit 15 toward bit 0. Starting at 0 with register 0 = 8, code 5 visits 0, 8, 4, 12, 2, 10, 6, 14, 1, 9, ... (the 4-bit bit-reversed order).
- R6: Pointer registers change only through an accepted pointer-mode request or the load port. A paged-mode request leaves them untouched, whatever its update code.
- R7: When an accepted request has `req_ptr_load`=1, the selector takes `req_ptr_val` at that edge. That request still uses the old selector, and the next request uses the new one.
- R8: `ar_wr` writes `ar_val` into register `ar_sel` at the clock edge. If the same register is being updated by an accepted request in that cycle, the write wins. A write to a different register and the update both take effect.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `addr_valid` is low or `addr_ready` is high.
- R10: Each accepted request yields exactly one result, in order, one cycle later. While `addr_valid`=1 and `addr_ready`=0, `addr_out` and `addr_valid` hold.
- R11: After reset, all pointer registers, the selector and the page register are zero, and `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_indirect | input | 1 | 1 = pointer mode, 0 = paged mode |
| req_offset | input | 7 | Offset field for paged mode |
| req_upd | input | 3 | Update code for the selected pointer register |
| req_ptr_load | input | 1 | Load the selector after this access |
| req_ptr_val | input | 3 | New selector value |
| page_wr | input | 1 | Load the page register |
| page_val | input | 9 | Page register value |
| ar_wr | input | 1 | Write a pointer register |
| ar_sel | input | 3 | Pointer register to write |
| ar_val | input | 16 | Value to write |
| addr_valid | output | 1 | Result present |
| addr_ready | input | 1 | Consumer takes the result |
| addr_out | output | 16 | Effective data address |

## Verification
The hardest case to reach is a load-port write that lands in the same cycle as a pointer update of the same register. This only happens when a request is accepted during the write, so the driver can raise `ar_wr` together with a request for the very register it targets. The result is then read back by a follow-up access with no update. Back-pressure stalls come from a consumer that drops `addr_ready` in a fixed rhythm plus one long stretch, so requests are also accepted in cycles where the output register is draining. The reversed-carry walk over a 16-point buffer is compared with a bench model that ripples carries from the top bit down.

// File: rtl/dag_pkg.sv
`timescale 1ns/100ps
package dag_pkg;
  typedef enum logic [2:0] {
    UPD_HOLD = 3'd0,
    UPD_INC  = 3'd1,
    UPD_DEC  = 3'd2,
    UPD_ADDX = 3'd3,
    UPD_SUBX = 3'd4,
    UPD_RADD = 3'd5,
    UPD_RSUB = 3'd6,
    UPD_RSVD = 3'd7
  } upd_e;
endpackage

// File: rtl/dag_step.sv
`timescale 1ns/100ps
module dag_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] idx,
  input  logic [2:0]   code,
  output logic [W-1:0] nxt
);
  import dag_pkg::*;

  logic [W-1:0] cur_r, idx_r, rsum, rdif, rsum_b, rdif_b;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rev
      assign cur_r[i]  = cur[W-1-i];
      assign idx_r[i]  = idx[W-1-i];
      assign rsum_b[i] = rsum[W-1-i];
      assign rdif_b[i] = rdif[W-1-i];
    end
  endgenerate

  assign rsum = cur_r + idx_r;
  assign rdif = cur_r - idx_r;

  always_comb begin
    unique case (upd_e'(code))
      UPD_INC:  nxt = cur + W'(1);
      UPD_DEC:  nxt = cur - W'(1);
      UPD_ADDX: nxt = cur + idx;
      UPD_SUBX: nxt = cur - idx;
      UPD_RADD: nxt = rsum_b;
      UPD_RSUB: nxt = rdif_b;
      default:  nxt = cur;
    endcase
  end

  // R5: a reversed step by zero must leave the value alone
  always_comb begin
    a_r5_zero_step: assert (!((code == 3'd5 || code == 3'd6) && idx == '0) || nxt == cur);
  end
endmodule

// File: rtl/dag_arfile.sv
`timescale 1ns/100ps
module dag_arfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  idx_data,
  input  logic          mod_en,
  input  logic [W-1:0]  mod_val,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_val
);
  logic [W-1:0] regs [N];

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[k] <= '0;
        else if (wr_en && wr_sel == SW'(k))
          regs[k] <= wr_val;
        else if (mod_en && rd_sel == SW'(k))
          regs[k] <= mod_val;
      end
    end
  endgenerate

  assign rd_data  = regs[rd_sel];
  assign idx_data = regs[0];

  a_r8_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_sel)] == $past(wr_val));

  a_r4_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !(wr_en && wr_sel == rd_sel)) |=> regs[$past(rd_sel)] == $past(mod_val));
endmodule

// File: rtl/dsp_addr_gen.sv
`timescale 1ns/100ps
module dsp_addr_gen #(
  parameter int AW     = 16,
  parameter int PAGE_W = 9,
  parameter int NAR    = 8,
  localparam int OFF_W = AW - PAGE_W,
  localparam int SEL_W = $clog2(NAR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indirect,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [2:0]        req_upd,
  input  logic              req_ptr_load,
  input  logic [SEL_W-1:0]  req_ptr_val,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              ar_wr,
  input  logic [SEL_W-1:0]  ar_sel,
  input  logic [AW-1:0]     ar_val,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [AW-1:0]     addr_out
);
  logic [SEL_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     cur, idx, nxt, ea;
  logic              accept;

  assign req_ready = !addr_valid || addr_ready;
  assign accept    = req_valid && req_ready;

  dag_arfile #(.W(AW), .N(NAR)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel   (ptr_q),
    .rd_data  (cur),
    .idx_data (idx),
    .mod_en   (accept && req_indirect),
    .mod_val  (nxt),
    .wr_en    (ar_wr),
    .wr_sel   (ar_sel),
    .wr_val   (ar_val)
  );

  dag_step #(.W(AW)) u_step (
    .cur  (cur),
    .idx  (idx),
    .code (req_upd),
    .nxt  (nxt)
  );

  assign ea = req_indirect ? cur : {page_q, req_offset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else if (accept) begin
      addr_valid <= 1'b1;
      addr_out   <= ea;
    end else if (addr_ready) begin
      addr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ptr_q <= '0;
    else if (accept && req_ptr_load) ptr_q <= req_ptr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_wr) page_q <= page_val;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_indirect) |=> addr_out[OFF_W-1:0] == $past(req_offset));

  a_r7_select: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ptr_load) |=> ptr_q == $past(req_ptr_val));

  a_r9_result: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> addr_valid);
endmodule

// File: tb/dsp_addr_gen_tb.sv
`timescale 1ns/100ps
module dsp_addr_gen_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_indirect = 0, req_ptr_load = 0;
  logic [6:0]  req_offset = 0;
  logic [2:0]  req_upd = 0, req_ptr_val = 0, ar_sel = 0;
  logic        page_wr = 0, ar_wr = 0, addr_ready = 1;
  logic [8:0]  page_val = 0;
  logic [15:0] ar_val = 0;
  logic        req_ready, addr_valid;
  logic [15:0] addr_out;

  always #2 clk = ~clk;

  dsp_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_indirect(req_indirect), .req_offset(req_offset), .req_upd(req_upd),
    .req_ptr_load(req_ptr_load), .req_ptr_val(req_ptr_val),
    .page_wr(page_wr), .page_val(page_val), .ar_wr(ar_wr), .ar_sel(ar_sel),
    .ar_val(ar_val), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit stall_mode = 1;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] m_ar [8];
  logic [2:0]  m_ptr = 0;
  logic [8:0]  m_page = 0;

  function automatic logic [15:0] rev_add(input logic [15:0] a, input logic [15:0] b, input bit sub);
    logic [15:0] r; logic c; logic bb;
    c = sub;
    for (int i = 15; i >= 0; i--) begin
      bb = sub ? ~b[i] : b[i];
      r[i] = a[i] ^ bb ^ c;
      c = (a[i] & bb) | (c & (a[i] ^ bb));
    end
    return r;
  endfunction

  function automatic logic [15:0] model_step(input logic [15:0] v, input logic [2:0] code);
    case (code)
      3'd1: return v + 16'd1;
      3'd2: return v - 16'd1;
      3'd3: return v + m_ar[0];
      3'd4: return v - m_ar[0];
      3'd5: return rev_add(v, m_ar[0], 1'b0);
      3'd6: return rev_add(v, m_ar[0], 1'b1);
      default: return v;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit ind, input logic [6:0] off, input logic [2:0] upd,
                     input bit pl, input logic [2:0] pv,
                     input bit w, input logic [2:0] ws, input logic [15:0] wv,
                     input string tag);
    logic [15:0] e;
    @(negedge clk); #1;
    req_valid = 1; req_indirect = ind; req_offset = off; req_upd = upd;
    req_ptr_load = pl; req_ptr_val = pv; ar_wr = w; ar_sel = ws; ar_val = wv;
    while (!req_ready) begin @(negedge clk); #1; end
    if (ind) begin
      e = m_ar[m_ptr];
      m_ar[m_ptr] = model_step(m_ar[m_ptr], upd);
    end else e = {m_page, off};
    if (w) m_ar[ws] = wv;
    if (pl) m_ptr = pv;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0; ar_wr = 0; req_ptr_load = 0;
  endtask

  task automatic load_ar(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk); #1; ar_wr = 1; ar_sel = s; ar_val = v;
    @(posedge clk); #1; ar_wr = 0; m_ar[s] = v;
  endtask

  task automatic load_page(input logic [8:0] p);
    @(negedge clk); #1; page_wr = 1; page_val = p;
    @(posedge clk); #1; page_wr = 0; m_page = p;
  endtask

  task automatic rd(input logic [2:0] s, input string tag);
    acc(1, 0, 3'd0, 1, s, 0, 0, 0, tag);
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: drives back-pressure and pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      addr_ready = !stall_mode || ((cyc % 5) != 3 && !(cyc > 150 && cyc < 165));
      #1.5;
      if (rst_n && addr_valid && addr_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R10: actual extra result %h expected none", addr_out);
        end else check(tag_q.pop_front(), addr_out, exp_q.pop_front());
      end
    end
  end

  // R10: result held while stalled
  logic [15:0] held;
  initial begin
    forever begin
      @(negedge clk); #1.6;
      if (rst_n && addr_valid && !addr_ready) begin
        held = addr_out;
        @(negedge clk); #1.6;
        check("R10 hold", {15'd0, addr_valid}, 16'd1);
        check("R10 hold", addr_out, held);
        check("R9 ready", {15'd0, req_ready}, {15'd0, addr_ready});
      end
    end
  end

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #80000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ar[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check("R11 valid", {15'd0, addr_valid}, 16'd0);
    check("R9 ready", {15'd0, req_ready}, 16'd1);
    // R11: registers start at zero, selector 0
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R11 ar0");
    rd(3'd5, "R11 ar5");
    acc(0, 7'h15, 3'd0, 0, 0, 0, 0, 0, "R11 page");
    // R1 / R2 paged mode
    load_page(9'h0A3);
    acc(0, 7'h00, 3'd0, 0, 0, 0, 0, 0, "R1 direct");
    acc(0, 7'h55, 3'd1, 0, 0, 0, 0, 0, "R1 direct");
    load_page(9'h1FF);
    acc(0, 7'h7F, 3'd0, 0, 0, 0, 0, 0, "R2 top");
    load_page(9'h000);
    acc(0, 7'h7F, 3'd0, 0, 0, 0, 0, 0, "R2 bottom");
    // R3 / R7 selection
    for (int i = 0; i < 8; i++) load_ar(i[2:0], 16'h1000 + 16'(i * 16'h111));
    for (int i = 7; i >= 0; i--) rd(i[2:0], "R3 select");
    acc(1, 0, 3'd0, 1, 3'd2, 0, 0, 0, "R7 old sel");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R7 new sel");
    // R4 arithmetic and wrap
    load_ar(3'd2, 16'hFFFF);
    acc(1, 0, 3'd1, 0, 0, 0, 0, 0, "R4 inc");
    acc(1, 0, 3'd2, 0, 0, 0, 0, 0, "R4 wrap");
    acc(1, 0, 3'd2, 0, 0, 0, 0, 0, "R4 dec");
    acc(1, 0, 3'd7, 0, 0, 0, 0, 0, "R4 rsvd");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R4 rsvd");
    load_ar(3'd0, 16'h0030);
    acc(1, 0, 3'd3, 0, 0, 0, 0, 0, "R4 addx");
    acc(1, 0, 3'd4, 0, 0, 0, 0, 0, "R4 subx");
    acc(1, 0, 3'd4, 0, 0, 0, 0, 0, "R4 subx");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R4 subx");
    // R6: paged request does not touch registers
    acc(0, 7'h01, 3'd1, 0, 0, 0, 0, 0, "R6 paged");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R6 unchanged");
    // R5: 16-point bit-reversed walk, forward then back
    load_ar(3'd0, 16'd8);
    load_ar(3'd4, 16'd0);
    acc(1, 0, 3'd0, 1, 3'd4, 0, 0, 0, "R5 setup");
    for (int k = 0; k < 18; k++) acc(1, 0, 3'd5, 0, 0, 0, 0, 0, "R5 radd");
    for (int k = 0; k < 18; k++) acc(1, 0, 3'd6, 0, 0, 0, 0, 0, "R5 rsub");
    load_ar(3'd0, 16'h0100);
    for (int k = 0; k < 6; k++) acc(1, 0, 3'd5, 0, 0, 0, 0, 0, "R5 wide");
    // R8: load port beats update of the same register
    acc(1, 0, 3'd1, 0, 0, 1, 3'd4, 16'hBEEF, "R8 same");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R8 same");
    acc(1, 0, 3'd1, 0, 0, 1, 3'd6, 16'h1234, "R8 other");
    acc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R8 other");
    rd(3'd6, "R8 other");
    // R9/R10 without stalls: back-to-back stream
    stall_mode = 0;
    for (int k = 0; k < 8; k++) acc(1, 0, 3'd1, 0, 0, 0, 0, 0, "R9 stream");
    stall_mode = 1;
    for (int k = 0; k < 60; k++) acc(k[0], 7'(k), 3'd2, 0, 0, 0, 0, 0, "R10 stall");
    repeat (40) @(posedge clk);
    check("R10 drained", 16'(exp_q.size()), 16'd0);
    finish_up();
  end
endmodule